// File: doc/BRIEF.md
# Drawing Engine Register File

This block is the register file of a 2D drawing engine. Two masters write into one 32-bit register space that is addressed by dword index. The first is a host bus, which presents a word address, write data and a per-byte lane mask. The second is a command-list sequencer. The sequencer accepts a "set register" command made of a start index and a dword count, then writes each data beat it receives to the next consecutive index with every byte lane enabled.

The file holds four writable registers: the framebuffer base address, the horizontal resolution, the foreground colour and the background colour. On every write the incoming data is merged into the old value under the byte mask, and only then is the result cut down to the register's legal width. Engine status arrives on external inputs. The block packs it into a read-only control word and also shows each status field right-justified in its own read-only alias register. Every other index reads as zero and ignores writes.

The sequencer has two states. In `SEQ_IDLE`, the transition *load* moves it to `SEQ_BURST` when a start arrives with a non-zero count, and a start with a zero count leaves it in `SEQ_IDLE`. In `SEQ_BURST`, the transition *beat* writes one dword and advances, and the transition *drain* returns to `SEQ_IDLE` on the last beat.

Top module: `draw_regfile`

## Requirements
- R1: After reset, the four writable registers read zero, `cmd_busy` is low and `host_ready` is high.
- R2: A host write changes only the byte lanes whose `host_be` bit is set. Bit n covers data bits [8n+7:8n]. Reads are combinational from `host_addr`.
- R3: The framebuffer base at index 0x110 keeps only bits [25:0] of the merged value and is driven on `fb_base`.
- R4: The horizontal resolution at index 0x111 keeps only bits [11:0] and is driven on `xres`.
- R5: The foreground colour at index 0x120 and the background colour at index 0x121 keep only bits [15:0]. Lanes above bit 15 that are written have no effect.
- R6: The control word at index 0x100 reads as follows: error status in [24:22], FIFO count in [19:15], FIFO status in [14:12], setup status in [9:8], DDA status in [5:4] and pixel status in [1:0]. All other bits read zero.
- R7: The alias indices show single status fields, right-justified: 0x101 shows FIFO status, 0x102 FIFO count, 0x103 setup status, 0x104 DDA status, 0x105 pixel status and 0x106 error status.
- R8: Unimplemented indices read zero. Writes to them, to the control word or to the aliases change nothing.
- R9: A `cmd_start` in `SEQ_IDLE` with count N>0 raises `cmd_busy` from the next cycle. The next N cycles that have `cmd_data_valid` write `cmd_data` with a full mask to index, index+1, and so on. `cmd_busy` falls after the last beat. A count of 0 writes nothing and leaves `cmd_busy` low.
- R10: When a command beat and a host write fall in the same cycle, the command write is applied, `host_ready` is low and the host write is dropped. The host write is applied when it is presented again with `host_ready` high.
- R11: A `cmd_start` during `SEQ_BURST` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access valid |
| host_we | input | 1 | Host access is a write |
| host_addr | input | ADDR_W | Host dword index |
| host_wdata | input | 32 | Host write data |
| host_be | input | 4 | Host byte-lane mask |
| host_rdata | output | 32 | Read data for `host_addr` |
| host_ready | output | 1 | Low when a host write is stalled |
| cmd_start | input | 1 | Start a register-set command |
| cmd_index | input | ADDR_W | First dword index of the command |
| cmd_count | input | CNT_W | Number of dwords in the command |
| cmd_data_valid | input | 1 | Command data beat valid |
| cmd_data | input | 32 | Command data beat |
| cmd_busy | output | 1 | Sequencer is in `SEQ_BURST` |
| st_fifo | input | 3 | FIFO status field |
| st_fifo_cnt | input | 5 | FIFO count field |
| st_setup | input | 2 | Setup status field |
| st_dda | input | 2 | DDA status field |
| st_pixel | input | 2 | Pixel status field |
| st_error | input | 3 | Error status field |
| fb_base | output | 26 | Framebuffer base register |
| xres | output | 12 | Horizontal resolution register |
| fg_color | output | 16 | Foreground colour register |
| bg_color | output | 16 | Background colour register |

## Verification
The bench builds the block with ADDR_W=10, which still reaches every implemented index. It also sets CNT_W=3, which limits a command to at most seven beats. With these narrow fields, the zero-count case, a burst that sweeps from an unimplemented index into both colour registers, and a burst interrupted by gaps in `cmd_data_valid` all stay short. A few dozen cycles are also enough to cover collisions and ignored restarts inside a burst.

// File: rtl/draw_regs_pkg.sv
package draw_regs_pkg;

    localparam int DATA_W    = 32;
    localparam int BE_W      = DATA_W / 8;
    localparam int NUM_STORE = 4;
    localparam int NUM_ALIAS = 6;

    localparam int IDX_CTRL  = 'h100;
    localparam int IDX_ALIAS = 'h101;
    localparam int IDX_FB    = 'h110;
    localparam int IDX_XRES  = 'h111;
    localparam int IDX_FG    = 'h120;
    localparam int IDX_BG    = 'h121;

    typedef enum logic [0:0] {
        SEQ_IDLE  = 1'b0,
        SEQ_BURST = 1'b1
    } seq_state_t;

    function automatic int store_index(input int i);
        case (i)
            0:       return IDX_FB;
            1:       return IDX_XRES;
            2:       return IDX_FG;
            default: return IDX_BG;
        endcase
    endfunction

    function automatic int store_width(input int i);
        case (i)
            0:       return 26;
            1:       return 12;
            default: return 16;
        endcase
    endfunction

    function automatic int alias_lsb(input int i);
        case (i)
            0:       return 12;
            1:       return 15;
            2:       return 8;
            3:       return 4;
            4:       return 0;
            default: return 22;
        endcase
    endfunction

    function automatic int alias_width(input int i);
        case (i)
            0:       return 3;
            1:       return 5;
            5:       return 3;
            default: return 2;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] alias_mask(input int i);
        return (32'd1 << alias_width(i)) - 32'd1;
    endfunction

endpackage

// File: rtl/draw_cmd_seq.sv
module draw_cmd_seq
    import draw_regs_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_index,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic              cmd_data_valid,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              busy,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    seq_state_t        state_q, state_d;
    logic [ADDR_W-1:0] ptr_q;
    logic [CNT_W-1:0]  remain_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (cmd_start && (cmd_count != '0))
                    state_d = SEQ_BURST;
            end
            SEQ_BURST: begin
                if (cmd_data_valid && (remain_q == CNT_W'(1)))
                    state_d = SEQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            ptr_q    <= '0;
            remain_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SEQ_IDLE && cmd_start) begin
                ptr_q    <= cmd_index;
                remain_q <= cmd_count;
            end else if (state_q == SEQ_BURST && cmd_data_valid) begin
                ptr_q    <= ptr_q + ADDR_W'(1);
                remain_q <= remain_q - CNT_W'(1);
            end
        end
    end

    always_comb begin
        busy    = (state_q == SEQ_BURST);
        wr_en   = (state_q == SEQ_BURST) && cmd_data_valid;
        wr_addr = ptr_q;
        wr_data = cmd_data;
    end

    assert_zero_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_IDLE && cmd_start && cmd_count == '0) |=> (state_q == SEQ_IDLE));

    assert_ptr_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_BURST && cmd_data_valid && remain_q != CNT_W'(1))
        |=> (ptr_q == $past(ptr_q) + ADDR_W'(1)));

    assert_restart_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_BURST && cmd_start && !cmd_data_valid)
        |=> (state_q == SEQ_BURST && ptr_q == $past(ptr_q)));

endmodule

// File: rtl/draw_wr_arb.sv
module draw_wr_arb
    import draw_regs_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [BE_W-1:0]   host_be,
    input  logic              cmd_wr,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              host_ready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [BE_W-1:0]   wr_be
);

    logic host_wr;

    always_comb begin
        host_wr    = host_req && host_we;
        host_ready = !(host_wr && cmd_wr);
        wr_en      = host_wr || cmd_wr;
        if (cmd_wr) begin
            wr_addr = cmd_addr;
            wr_data = cmd_wdata;
            wr_be   = '1;
        end else begin
            wr_addr = host_addr;
            wr_data = host_wdata;
            wr_be   = host_be;
        end
    end

endmodule

// File: rtl/draw_reg_store.sv
module draw_reg_store
    import draw_regs_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic [BE_W-1:0]                   wr_be,
    output logic [NUM_STORE-1:0][DATA_W-1:0]  q
);

    logic [DATA_W-1:0] lane_mask;

    always_comb begin
        for (int b = 0; b < BE_W; b++)
            lane_mask[8*b +: 8] = {8{wr_be[b]}};
    end

    for (genvar gi = 0; gi < NUM_STORE; gi++) begin : g_reg
        localparam int W   = store_width(gi);
        localparam int IDX = store_index(gi);
        logic [DATA_W-1:0] merged;

        always_comb merged = (q[gi] & ~lane_mask) | (wr_data & lane_mask);

        always_ff @(posedge clk) begin
            if (!rst_n)
                q[gi] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(IDX))
                q[gi] <= {{(DATA_W-W){1'b0}}, merged[W-1:0]};
        end
    end

    assert_fb_trim_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(IDX_FB) && wr_be == '1)
        |=> (q[0] == {6'b0, $past(wr_data[25:0])}));

    assert_fg_lane_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(IDX_FG) && wr_be == 4'b0001)
        |=> (q[2][15:8] == $past(q[2][15:8])));

endmodule

// File: rtl/draw_rd_mux.sv
module draw_rd_mux
    import draw_regs_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic [ADDR_W-1:0]                rd_addr,
    input  logic [DATA_W-1:0]                ctrl_word,
    input  logic [NUM_STORE-1:0][DATA_W-1:0] store_q,
    output logic [DATA_W-1:0]                rdata
);

    always_comb begin
        rdata = '0;
        if (rd_addr == ADDR_W'(IDX_CTRL))
            rdata = ctrl_word;
        for (int i = 0; i < NUM_ALIAS; i++) begin
            if (rd_addr == ADDR_W'(IDX_ALIAS + i))
                rdata = (ctrl_word >> alias_lsb(i)) & alias_mask(i);
        end
        for (int i = 0; i < NUM_STORE; i++) begin
            if (rd_addr == ADDR_W'(store_index(i)))
                rdata = store_q[i];
        end
    end

endmodule

// File: rtl/draw_regfile.sv
module draw_regfile
    import draw_regs_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    input  logic [3:0]        host_be,
    output logic [31:0]       host_rdata,
    output logic              host_ready,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_index,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic              cmd_data_valid,
    input  logic [31:0]       cmd_data,
    output logic              cmd_busy,
    input  logic [2:0]        st_fifo,
    input  logic [4:0]        st_fifo_cnt,
    input  logic [1:0]        st_setup,
    input  logic [1:0]        st_dda,
    input  logic [1:0]        st_pixel,
    input  logic [2:0]        st_error,
    output logic [25:0]       fb_base,
    output logic [11:0]       xres,
    output logic [15:0]       fg_color,
    output logic [15:0]       bg_color
);

    logic              cmd_wr;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_wdata;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [BE_W-1:0]   wr_be;
    logic [DATA_W-1:0] ctrl_word;
    logic [NUM_STORE-1:0][DATA_W-1:0] store_q;

    draw_cmd_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_start(cmd_start), .cmd_index(cmd_index), .cmd_count(cmd_count),
        .cmd_data_valid(cmd_data_valid), .cmd_data(cmd_data),
        .busy(cmd_busy), .wr_en(cmd_wr), .wr_addr(cmd_addr), .wr_data(cmd_wdata)
    );

    draw_wr_arb #(.ADDR_W(ADDR_W)) u_arb (
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_be(host_be),
        .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .host_ready(host_ready), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be)
    );

    draw_reg_store #(.ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be), .q(store_q)
    );

    always_comb begin
        ctrl_word        = '0;
        ctrl_word[24:22] = st_error;
        ctrl_word[19:15] = st_fifo_cnt;
        ctrl_word[14:12] = st_fifo;
        ctrl_word[9:8]   = st_setup;
        ctrl_word[5:4]   = st_dda;
        ctrl_word[1:0]   = st_pixel;
    end

    draw_rd_mux #(.ADDR_W(ADDR_W)) u_rd (
        .rd_addr(host_addr), .ctrl_word(ctrl_word), .store_q(store_q), .rdata(host_rdata)
    );

    always_comb begin
        fb_base  = store_q[0][25:0];
        xres     = store_q[1][11:0];
        fg_color = store_q[2][15:0];
        bg_color = store_q[3][15:0];
    end

    assert_stall_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_we && !host_ready) |-> cmd_wr);

    assert_dropped_host_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_ready && cmd_wr && cmd_addr != ADDR_W'(IDX_BG) && host_addr == ADDR_W'(IDX_BG))
        |=> $stable(bg_color));

endmodule

// File: tb/draw_regfile_tb.sv
module draw_regfile_tb_top;

    localparam int AW = 10;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_req = 1'b0, host_we = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [31:0]   host_wdata = '0;
    logic [3:0]    host_be = '0;
    logic [31:0]   host_rdata;
    logic          host_ready;
    logic          cmd_start = 1'b0;
    logic [AW-1:0] cmd_index = '0;
    logic [CW-1:0] cmd_count = '0;
    logic          cmd_data_valid = 1'b0;
    logic [31:0]   cmd_data = '0;
    logic          cmd_busy;
    logic [2:0]    st_fifo = '0;
    logic [4:0]    st_fifo_cnt = '0;
    logic [1:0]    st_setup = '0, st_dda = '0, st_pixel = '0;
    logic [2:0]    st_error = '0;
    logic [25:0]   fb_base;
    logic [11:0]   xres;
    logic [15:0]   fg_color, bg_color;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    draw_regfile #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_be(host_be), .host_rdata(host_rdata),
        .host_ready(host_ready),
        .cmd_start(cmd_start), .cmd_index(cmd_index), .cmd_count(cmd_count),
        .cmd_data_valid(cmd_data_valid), .cmd_data(cmd_data), .cmd_busy(cmd_busy),
        .st_fifo(st_fifo), .st_fifo_cnt(st_fifo_cnt), .st_setup(st_setup),
        .st_dda(st_dda), .st_pixel(st_pixel), .st_error(st_error),
        .fb_base(fb_base), .xres(xres), .fg_color(fg_color), .bg_color(bg_color)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic host_wr(input int idx, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = AW'(idx);
        host_wdata = d; host_be = be;
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
    endtask

    task automatic host_rd(input int idx, output logic [31:0] d);
        @(negedge clk);
        host_addr = AW'(idx);
        #1 d = host_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        host_rd('h110, d); chk("R1 fb", d, 0);
        host_rd('h111, d); chk("R1 xres", d, 0);
        host_rd('h120, d); chk("R1 fg", d, 0);
        host_rd('h121, d); chk("R1 bg", d, 0);
        chk("R1 busy", 32'(cmd_busy), 0);
        chk("R1 ready", 32'(host_ready), 1);
    endtask

    task automatic t_merge;
        logic [31:0] d;
        host_wr('h120, 32'h0000_1234, 4'hF);
        host_wr('h120, 32'hABCD_5678, 4'b0010);
        host_rd('h120, d); chk("R2 lane merge", d, 32'h5634);
        host_wr('h120, 32'hABCD_9999, 4'b0100);
        host_rd('h120, d); chk("R5 upper lane dropped", d, 32'h5634);
        chk("R5 fg port", 32'(fg_color), 32'h5634);
        host_wr('h121, 32'hFFFF_BEEF, 4'hF);
        chk("R5 bg port", 32'(bg_color), 32'hBEEF);
    endtask

    task automatic t_trim;
        logic [31:0] d;
        host_wr('h110, 32'hFFFF_FFFF, 4'hF);
        host_rd('h110, d); chk("R3 fb read", d, 32'h03FF_FFFF);
        chk("R3 fb port", 32'(fb_base), 32'h03FF_FFFF);
        host_wr('h110, 32'h0000_0000, 4'b0001);
        chk("R3 fb lane0 cleared", 32'(fb_base), 32'h03FF_FF00);
        host_wr('h111, 32'hDEAD_BEEF, 4'hF);
        host_rd('h111, d); chk("R4 xres read", d, 32'h0EEF);
        chk("R4 xres port", 32'(xres), 32'h0EEF);
    endtask

    task automatic t_status;
        logic [31:0] d, exp;
        @(negedge clk);
        st_error = 3'b101; st_fifo_cnt = 5'b10011; st_fifo = 3'b110;
        st_setup = 2'b10; st_dda = 2'b01; st_pixel = 2'b11;
        exp = (32'd5 << 22) | (32'h13 << 15) | (32'd6 << 12) | (32'd2 << 8) | (32'd1 << 4) | 32'd3;
        host_rd('h100, d); chk("R6 control", d, exp);
        host_rd('h101, d); chk("R7 fifo status", d, 6);
        host_rd('h102, d); chk("R7 fifo count", d, 32'h13);
        host_rd('h103, d); chk("R7 setup", d, 2);
        host_rd('h104, d); chk("R7 dda", d, 1);
        host_rd('h105, d); chk("R7 pixel", d, 3);
        host_rd('h106, d); chk("R7 error", d, 5);
    endtask

    task automatic t_unimpl;
        logic [31:0] d;
        host_wr('h100, 32'hFFFF_FFFF, 4'hF);
        host_rd('h100, d); chk("R8 control not written", d, 32'h0149_E213);
        host_wr('h102, 32'h0000_0000, 4'hF);
        host_rd('h102, d); chk("R8 alias not written", d, 32'h13);
        host_wr('h130, 32'h1234_5678, 4'hF);
        host_rd('h130, d); chk("R8 unimplemented", d, 0);
        host_rd('h112, d); chk("R8 gap index", d, 0);
        chk("R8 regs untouched", {fg_color, bg_color}, 32'h5634_BEEF);
    endtask

    task automatic t_burst;
        @(negedge clk);
        cmd_start = 1'b1; cmd_index = AW'('h11F); cmd_count = CW'(3);
        @(negedge clk);
        cmd_start = 1'b0;
        chk("R9 busy after start", 32'(cmd_busy), 1);
        cmd_data_valid = 1'b1; cmd_data = 32'hAAAA_1111;
        @(negedge clk);
        cmd_data_valid = 1'b0;
        @(negedge clk);
        chk("R9 busy during gap", 32'(cmd_busy), 1);
        cmd_data_valid = 1'b1; cmd_data = 32'hBBBB_2222;
        @(negedge clk);
        cmd_data = 32'hCCCC_3333;
        @(negedge clk);
        cmd_data_valid = 1'b0;
        chk("R9 busy after last", 32'(cmd_busy), 0);
        chk("R9 fg from burst", 32'(fg_color), 32'h2222);
        chk("R9 bg from burst", 32'(bg_color), 32'h3333);
        chk("R9 fb untouched", 32'(fb_base), 32'h03FF_FF00);
    endtask

    task automatic t_zero_count;
        @(negedge clk);
        cmd_start = 1'b1; cmd_index = AW'('h120); cmd_count = '0;
        @(negedge clk);
        cmd_start = 1'b0;
        chk("R9 zero count idle", 32'(cmd_busy), 0);
        cmd_data_valid = 1'b1; cmd_data = 32'h0000_FFFF;
        @(negedge clk);
        cmd_data_valid = 1'b0;
        chk("R9 zero count no write", 32'(fg_color), 32'h2222);
    endtask

    task automatic t_collision;
        @(negedge clk);
        cmd_start = 1'b1; cmd_index = AW'('h120); cmd_count = CW'(1);
        @(negedge clk);
        cmd_start = 1'b0;
        cmd_data_valid = 1'b1; cmd_data = 32'h0000_4444;
        host_req = 1'b1; host_we = 1'b1; host_addr = AW'('h121);
        host_wdata = 32'h0000_7777; host_be = 4'hF;
        #1 chk("R10 ready low", 32'(host_ready), 0);
        @(negedge clk);
        cmd_data_valid = 1'b0;
        chk("R10 cmd applied", 32'(fg_color), 32'h4444);
        chk("R10 host dropped", 32'(bg_color), 32'h3333);
        #1 chk("R10 ready restored", 32'(host_ready), 1);
        @(negedge clk);
        host_req = 1'b0; host_we = 1'b0;
        chk("R10 host retried", 32'(bg_color), 32'h7777);
    endtask

    task automatic t_restart;
        @(negedge clk);
        cmd_start = 1'b1; cmd_index = AW'('h120); cmd_count = CW'(2);
        @(negedge clk);
        cmd_index = AW'('h110); cmd_count = CW'(1);
        @(negedge clk);
        cmd_start = 1'b0;
        cmd_data_valid = 1'b1; cmd_data = 32'h0000_5555;
        @(negedge clk);
        cmd_data = 32'h0000_6666;
        @(negedge clk);
        cmd_data_valid = 1'b0;
        chk("R11 restart ignored fg", 32'(fg_color), 32'h5555);
        chk("R11 restart ignored bg", 32'(bg_color), 32'h6666);
        chk("R11 fb untouched", 32'(fb_base), 32'h03FF_FF00);
        chk("R11 idle after", 32'(cmd_busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_merge();
        t_trim();
        t_status();
        t_unimpl();
        t_burst();
        t_zero_count();
        t_collision();
        t_restart();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule